// File: doc/BRIEF.md
# Usage-Driven Voltage/Frequency Governor

This controller picks one of a small set of voltage/frequency operating points from a table that software can load. At the end of every measurement window it is given the number of active cycles counted in that window. It compares that number with an upper and a lower threshold and then moves at most one table step up, moves at most one step down, or stays where it is. The gap between the two thresholds gives hysteresis. The block drives a supply voltage code (in millivolts) and a clock ratio code (multiples of the reference clock). It does not model the regulator or the clock generator. Their settling times appear only as programmable wait counts.

A transition never changes both codes on the same cycle. On a step up, the voltage code moves first and the ratio code follows once the voltage settle count has run out. On a step down, the ratio code moves first and the voltage code follows once the frequency settle count has run out. While a transition is in flight, `busy` is high and window results are ignored. The lowest table entry is a fixed floor that software writes cannot alter.

Top module: `dvfs_governor`

## Requirements
- R1: After reset, `level` is 0, `volt_code` is 956, `ratio_code` is 6 and `busy` is 0.
- R2: A window pulse taken while not busy, with `act_count >= up_thresh` and `level` below NPTS-1, makes the next cycle show `level`+1 and `busy`=1. In that same cycle `volt_code` already carries the target entry's voltage and `ratio_code` is unchanged.
- R3: On a step up, `ratio_code` takes the target entry's ratio exactly `v_settle`+1 cycles after `volt_code` changed, and `busy` falls in that same cycle.
- R4: A window pulse taken while not busy, with `act_count < up_thresh`, `act_count <= dn_thresh` and `level` above 0, first moves `ratio_code` and sets `level`-1 and `busy`=1. `volt_code` follows `f_settle`+1 cycles later, and `busy` falls in that same cycle.
- R5: When a window's count lies strictly between the thresholds, nothing changes. Any single decision moves `level` by at most one step.
- R6: At the top entry an up request leaves everything unchanged. At entry 0 a down request leaves everything unchanged.
- R7: Window pulses that arrive while `busy` is high are ignored.
- R8: Writes to table index 0, and to indices of NPTS or more, are ignored. Entry 0 always reads as 956 mV with ratio 6.
- R9: After reset the table holds these entries, from index 0 to 5, as (mV, ratio): (956,6) (1036,8) (1164,10) (1276,12) (1420,14) (1484,16). A write with `tbl_we` at index 1..NPTS-1 replaces that entry and takes effect from the next transition onward.
- R10: When a count meets both thresholds, the up move wins.
- R11: `volt_code` and `ratio_code` never change on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_valid | input | 1 | One-cycle pulse marking the end of a window |
| act_count | input | CW | Active cycles counted in the finished window |
| up_thresh | input | CW | Count at or above which a step up is taken |
| dn_thresh | input | CW | Count at or below which a step down is taken |
| v_settle | input | SW | Wait cycles after a voltage rise |
| f_settle | input | SW | Wait cycles after a frequency drop |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | LW | Table entry to write |
| tbl_volt | input | VW | Voltage code to write |
| tbl_ratio | input | FW | Ratio code to write |
| volt_code | output | VW | Current voltage code in mV |
| ratio_code | output | FW | Current clock ratio code |
| level | output | LW | Current table index |
| busy | output | 1 | Transition in progress |

## Verification
If the transition state is wrong, the codes show it at the ports in the wrong order or at the wrong time. A ratio that moves before the voltage on a rise, or one that moves a cycle early or late compared with the settle count, is visible within settle+2 cycles of the window pulse. A level register that slips, or a decision taken while busy, leaves `level` and the codes at values that differ from the table entry the bench expects. That mismatch is visible at the next idle sample and persists for every later window.

// File: rtl/dvfs_governor.sv
module dvfs_governor #(
  parameter int NPTS = 6,
  parameter int CW   = 16,
  parameter int VW   = 11,
  parameter int FW   = 6,
  parameter int SW   = 12,
  parameter int LW   = $clog2(NPTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_valid,
  input  logic [CW-1:0] act_count,
  input  logic [CW-1:0] up_thresh,
  input  logic [CW-1:0] dn_thresh,
  input  logic [SW-1:0] v_settle,
  input  logic [SW-1:0] f_settle,
  input  logic          tbl_we,
  input  logic [LW-1:0] tbl_idx,
  input  logic [VW-1:0] tbl_volt,
  input  logic [FW-1:0] tbl_ratio,
  output logic [VW-1:0] volt_code,
  output logic [FW-1:0] ratio_code,
  output logic [LW-1:0] level,
  output logic          busy
);

  localparam logic [LW-1:0] TOP = LW'(NPTS - 1);

  function automatic logic [VW-1:0] dflt_v(input int i);
    case (i)
      0: return VW'(956);
      1: return VW'(1036);
      2: return VW'(1164);
      3: return VW'(1276);
      4: return VW'(1420);
      default: return VW'(1484);
    endcase
  endfunction

  function automatic logic [FW-1:0] dflt_r(input int i);
    return FW'(6 + 2 * i);
  endfunction

  typedef enum logic [1:0] {IDLE, UP_WAIT, DN_WAIT} st_t;

  logic [VW-1:0] tv [NPTS];
  logic [FW-1:0] tr [NPTS];
  st_t           st;
  logic [SW-1:0] cnt;
  logic [VW-1:0] pend_v;
  logic [FW-1:0] pend_r;

  for (genvar g = 0; g < NPTS; g++) begin : g_pt
    if (g == 0) begin : g_floor
      assign tv[g] = dflt_v(0);
      assign tr[g] = dflt_r(0);
    end else begin : g_prog
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          tv[g] <= dflt_v(g);
          tr[g] <= dflt_r(g);
        end else if (tbl_we && tbl_idx == LW'(g)) begin
          tv[g] <= tbl_volt;
          tr[g] <= tbl_ratio;
        end
      end
    end
  end

  logic          idle_win, want_up, go_up, go_dn;
  logic [LW-1:0] lvl_up, lvl_dn;

  assign idle_win = win_valid && st == IDLE;
  assign want_up  = act_count >= up_thresh;
  assign go_up    = idle_win && want_up && level != TOP;
  assign go_dn    = idle_win && !want_up && act_count <= dn_thresh && level != '0;
  assign lvl_up   = level + LW'(1);
  assign lvl_dn   = level - LW'(1);
  assign busy     = st != IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= IDLE;
      level      <= '0;
      volt_code  <= dflt_v(0);
      ratio_code <= dflt_r(0);
      cnt        <= '0;
      pend_v     <= '0;
      pend_r     <= '0;
    end else begin
      case (st)
        IDLE: begin
          if (go_up) begin
            volt_code <= tv[lvl_up];
            pend_r    <= tr[lvl_up];
            level     <= lvl_up;
            cnt       <= v_settle;
            st        <= UP_WAIT;
          end else if (go_dn) begin
            ratio_code <= tr[lvl_dn];
            pend_v     <= tv[lvl_dn];
            level      <= lvl_dn;
            cnt        <= f_settle;
            st         <= DN_WAIT;
          end
        end
        UP_WAIT: begin
          if (cnt == '0) begin
            ratio_code <= pend_r;
            st         <= IDLE;
          end else begin
            cnt <= cnt - SW'(1);
          end
        end
        default: begin
          if (cnt == '0) begin
            volt_code <= pend_v;
            st        <= IDLE;
          end else begin
            cnt <= cnt - SW'(1);
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/dvfs_governor_chk.sv
module dvfs_governor_chk #(
  parameter int NPTS = 6,
  parameter int VW   = 11,
  parameter int FW   = 6,
  parameter int LW   = $clog2(NPTS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [VW-1:0] volt_code,
  input logic [FW-1:0] ratio_code,
  input logic [LW-1:0] level,
  input logic          busy
);

  // R11
  split_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!$stable(volt_code) && !$stable(ratio_code)));

  // R2
  up_volt_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && level > $past(level)) |-> $stable(ratio_code));

  // R4
  dn_freq_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && level < $past(level)) |-> $stable(volt_code));

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(level));

  // R5
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level) |-> (level == $past(level) + LW'(1) || level + LW'(1) == $past(level)));

  // R6
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(NPTS - 1));

  // R8
  floor_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && level == '0) |-> (volt_code == VW'(956) && ratio_code == FW'(6)));

endmodule

bind dvfs_governor dvfs_governor_chk #(.NPTS(NPTS), .VW(VW), .FW(FW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .volt_code(volt_code), .ratio_code(ratio_code),
  .level(level), .busy(busy)
);

// File: tb/tb_dvfs_governor.sv
`timescale 1ns/1ps
module tb_dvfs_governor;
  localparam int NPTS = 6, CW = 16, VW = 11, FW = 6, SW = 12, LW = 3;

  logic          clk = 0, rst_n = 0, win_valid = 0, tbl_we = 0;
  logic [CW-1:0] act_count = 0, up_thresh = 700, dn_thresh = 300;
  logic [SW-1:0] v_settle = 2, f_settle = 3;
  logic [LW-1:0] tbl_idx = 0;
  logic [VW-1:0] tbl_volt = 0;
  logic [FW-1:0] tbl_ratio = 0;
  logic [VW-1:0] volt_code;
  logic [FW-1:0] ratio_code;
  logic [LW-1:0] level;
  logic          busy;

  dvfs_governor dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_v [NPTS] = '{956, 1036, 1164, 1276, 1420, 1484};
  int m_r [NPTS] = '{6, 8, 10, 12, 14, 16};
  int m_lvl = 0, cur_v = 956, cur_r = 6;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int decide(int act);
    if (act >= int'(up_thresh)) return (m_lvl < NPTS - 1) ? 1 : 0;
    if (act <= int'(dn_thresh) && m_lvl > 0) return -1;
    return 0;
  endfunction

  task automatic window(int act, bit ign, string req);
    int dir = decide(act);
    int vs = int'(v_settle), fs = int'(f_settle);
    @(negedge clk); win_valid = 1; act_count = CW'(act);
    @(negedge clk);
    if (ign) act_count = (dir > 0) ? CW'(0) : CW'(1000);
    else win_valid = 0;
    if (dir == 0) begin
      check(req, "hold busy", busy, 0);
      check(req, "hold level", level, m_lvl);
      check(req, "hold volt", volt_code, cur_v);
      check(req, "hold ratio", ratio_code, cur_r);
      win_valid = 0;
      return;
    end
    m_lvl += dir;
    check(req, "level step", level, m_lvl);
    check(req, "busy set", busy, 1);
    if (dir > 0) begin
      check("R2", "volt first", volt_code, m_v[m_lvl]);
      check("R2", "ratio held", ratio_code, cur_r);
      cur_v = m_v[m_lvl];
      repeat (vs) begin @(negedge clk); win_valid = 0; end
      check("R3", "ratio still old", ratio_code, cur_r);
      @(negedge clk); win_valid = 0;
      cur_r = m_r[m_lvl];
      check("R3", "ratio applied", ratio_code, cur_r);
    end else begin
      check("R4", "ratio first", ratio_code, m_r[m_lvl]);
      check("R4", "volt held", volt_code, cur_v);
      cur_r = m_r[m_lvl];
      repeat (fs) begin @(negedge clk); win_valid = 0; end
      check("R4", "volt still old", volt_code, cur_v);
      @(negedge clk); win_valid = 0;
      cur_v = m_v[m_lvl];
      check("R4", "volt applied", volt_code, cur_v);
    end
    check(req, "busy cleared", busy, 0);
    check(ign ? "R7" : req, "level after", level, m_lvl);
    check(req, "volt after", volt_code, cur_v);
  endtask

  task automatic wr(int idx, int v, int r);
    @(negedge clk); tbl_we = 1; tbl_idx = LW'(idx); tbl_volt = VW'(v); tbl_ratio = FW'(r);
    @(negedge clk); tbl_we = 0;
    if (idx > 0 && idx < NPTS) begin m_v[idx] = v; m_r[idx] = r; end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check("R1", "level", level, 0);
    check("R1", "volt", volt_code, 956);
    check("R1", "ratio", ratio_code, 6);
    check("R1", "busy", busy, 0);
    // R9 default table, stepped up to the top
    for (int i = 0; i < NPTS - 1; i++) window(900, 0, "R9");
    check("R9", "top volt", volt_code, 1484);
    check("R9", "top ratio", ratio_code, 16);
    window(1000, 0, "R6");
    window(500, 0, "R5");
    v_settle = 0; f_settle = 0;
    window(100, 0, "R4");
    window(800, 0, "R2");
    v_settle = 4; f_settle = 1;
    window(0, 1, "R7");
    window(1000, 1, "R7");
    // R10: count meets both thresholds
    up_thresh = 100; dn_thresh = 900;
    window(500, 0, "R10");
    up_thresh = 700; dn_thresh = 300;
    // R8 writes to entry 0 and out-of-range indices
    wr(0, 2000, 40);
    wr(6, 2000, 40);
    wr(7, 2000, 40);
    while (m_lvl > 0) window(0, 0, "R8");
    check("R8", "floor volt", volt_code, 956);
    check("R8", "floor ratio", ratio_code, 6);
    window(0, 0, "R6");
    wr(1, 1111, 9);
    window(900, 0, "R9");
    check("R9", "written volt", volt_code, 1111);
    for (int k = 0; k < 60; k++) begin
      if ($urandom_range(0, 3) == 0)
        wr($urandom_range(0, 7), $urandom_range(900, 1500), $urandom_range(6, 20));
      v_settle = SW'($urandom_range(0, 4));
      f_settle = SW'($urandom_range(0, 4));
      window($urandom_range(0, 1000), $urandom_range(0, 4) == 0, "R5");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2ms;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule